// File: doc/BRIEF.md
# Parallel Camera Frame Capture Engine

This block takes the byte stream of a parallel camera port (pixel clock, frame sync, line-valid and an 8-bit data bus), sampled in the system clock domain. It packs the bytes of each line into 64-bit beats and hands those beats to memory through a simple request/acknowledge write port. The line length is programmed as a number of beat groups. A group is one beat in single-beat mode or four beats in burst mode. The frame height is programmed as a line count.

Two outputs can be enabled on their own. The packed display output sends every beat to one base address. The planar output sends every beat to three plane base addresses in the order R, G, B. Colour-space splitting is outside this block, so each plane receives the raw beat. An 8-beat buffer separates the capture side from the write side. If that buffer is full, the incoming beat is dropped and an overflow flag is set.

Capture is armed by a status write, or on every frame when auto mode is on. Frame-start, frame-finish and overflow are sticky flags. Each flag is cleared only by a write-1 that is qualified by its own write-enable bit, and two of the flags can raise an interrupt. The block also produces the camera master clock by integer division of the system clock.

Top module: `cam_capture`

## Requirements
- R1: A byte is taken on a system-clock cycle where cam_pclk is high and was low on the previous cycle, and only while cam_href is high and a frame is being captured. Eight bytes make one beat, and the first byte goes to wr_data[7:0]. A line holds cfg_line_groups beats, or 4*cfg_line_groups beats when cfg_burst is 1. Further bytes in the same line are ignored.
- R2: A write to a target goes to that target's base address plus 8 times the beat's index in the frame. The index starts at 0 at each frame start.
- R3: With cfg_burst=0 every write is a single beat, with wr_first=1 and wr_last=1. With cfg_burst=1, the writes to each target come as runs of 4 consecutive beats, with wr_first on the first beat of the run and wr_last on the fourth.
- R4: While wr_req is high and wr_ack is low, wr_req, wr_addr and wr_data stay unchanged.
- R5: A rising edge on cam_vsync sets sts_flags[0] (frame-start) and restarts the line and beat counts.
- R6: sts_flags[1] (frame-finish) is set once cfg_lines lines have ended (href falling) and every write of the frame has been acknowledged.
- R7: The flags are sticky. A write with sts_wr=1 clears frame-start if sts_wdata[0] and sts_wdata[1] are both 1, frame-finish if bits 2 and 3 are both 1, and overflow if bits 6 and 7 are both 1. A flag bit written without its enable bit, or the other pair, leaves the flag unchanged.
- R8: A write with sts_wdata[5]=1 loads the arm bit (sts_flags[2]) from sts_wdata[4]. With cfg_auto=0, a frame start with the arm bit set captures that frame and clears the bit. A frame that starts unarmed produces no writes and no frame-finish.
- R9: With cfg_auto=1, every frame is captured and no arm write is needed.
- R10: irq is high while (sts_flags[0] and cfg_ie_start) or (sts_flags[1] and cfg_ie_finish).
- R11: With cfg_mclk_en=1, cam_mclk has a period of (cfg_mclk_div+1)*2 system clocks. With cfg_mclk_en=0, cam_mclk is held low.
- R12: For each group of beats, the writes go first to the display base (when cfg_disp_en=1), then to the R, G and B plane bases (when cfg_ai_en=1). With both enables clear, no writes are made.
- R13: When a beat completes while 8 beats are already buffered, that beat is dropped and sts_flags[3] (overflow) is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cam_pclk | input | 1 | Camera pixel clock, sampled |
| cam_vsync | input | 1 | Frame sync, rising edge starts a frame |
| cam_href | input | 1 | Line valid |
| cam_data | input | 8 | Camera byte |
| cam_mclk | output | 1 | Divided camera master clock |
| cfg_mclk_div | input | 8 | Master clock divider value |
| cfg_mclk_en | input | 1 | Master clock enable |
| cfg_line_groups | input | 8 | Beat groups per line |
| cfg_lines | input | 10 | Lines per frame |
| cfg_burst | input | 1 | 4-beat burst mode |
| cfg_auto | input | 1 | Capture every frame |
| cfg_disp_en | input | 1 | Packed display output enable |
| cfg_ai_en | input | 1 | Planar output enable |
| cfg_disp_base | input | 32 | Display base address |
| cfg_r_base | input | 32 | R plane base address |
| cfg_g_base | input | 32 | G plane base address |
| cfg_b_base | input | 32 | B plane base address |
| cfg_ie_start | input | 1 | Frame-start interrupt enable |
| cfg_ie_finish | input | 1 | Frame-finish interrupt enable |
| sts_wr | input | 1 | Status write strobe |
| sts_wdata | input | 8 | Status write data (flag/enable pairs) |
| sts_flags | output | 4 | {overflow, arm, finish, start} |
| irq | output | 1 | Interrupt |
| wr_req | output | 1 | Write request |
| wr_ack | input | 1 | Write accepted |
| wr_addr | output | 32 | Write byte address |
| wr_data | output | 64 | Write beat |
| wr_first | output | 1 | First beat of a run |
| wr_last | output | 1 | Last beat of a run |

## Verification
The hardest state to reach is overflow. The buffer fills only when the write side stalls for longer than eight beats of camera traffic. The bench withholds wr_ack for a whole 10-beat line, then releases it and checks three things: the overflow flag is set, exactly the first eight beats arrive at their addresses, and frame-finish still follows the drain. A second stress case acknowledges every request late while burst mode and all four targets are active. This case exercises holding a request steady in the middle of a run and moving between targets.

// File: rtl/cam_cap_pkg.sv
// Shared constants and types for the camera capture engine.
// Assumes: beats are 64 bits, frames hold fewer than 2^20 beats.
package cam_cap_pkg;
    localparam int BEAT_BYTES = 8;
    localparam int BEAT_W     = 64;
    localparam int IDX_W      = 20;
    localparam int ADDR_W     = 32;
    localparam int NTGT       = 4;
    // status write bit positions (flag, then its write-enable)
    localparam int ST_SOF    = 0;
    localparam int ST_SOF_WE = 1;
    localparam int ST_EOF    = 2;
    localparam int ST_EOF_WE = 3;
    localparam int ST_ARM    = 4;
    localparam int ST_ARM_WE = 5;
    localparam int ST_OVF    = 6;
    localparam int ST_OVF_WE = 7;

    typedef struct packed {
        logic [IDX_W-1:0]  idx;
        logic [BEAT_W-1:0] data;
    } beat_t;
endpackage

// File: rtl/cam_mclk_div.sv
// Integer divider for the camera master clock.
// Output toggles every DIV+1 input cycles; held low while disabled.
module cam_mclk_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             mclk
);
    logic [DIV_W-1:0] cnt;

    // count to div, then toggle the output
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt  <= '0;
            mclk <= 1'b0;
        end else if (cnt == div) begin
            cnt  <= '0;
            mclk <= ~mclk;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assert_mclk_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !mclk);
endmodule

// File: rtl/cam_cap_front.sv
// Camera front end: edge detection on the sampled port, byte packing into
// beats, per-line beat limiting and line counting.
// Assumes pclk/vsync/href/data are already synchronous to clk and that a
// pclk phase lasts at least one clk cycle.
module cam_cap_front
    import cam_cap_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int GRP_W  = 8,
    parameter int LINE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pclk,
    input  logic              vsync,
    input  logic              href,
    input  logic [DATA_W-1:0] data,
    input  logic              arm,
    input  logic [GRP_W-1:0]  groups,
    input  logic              burst,
    input  logic [LINE_W-1:0] lines,
    output logic              sof,
    output logic              beat_valid,
    output beat_t             beat,
    output logic              lines_done
);
    localparam int BPL_W  = GRP_W + 2;
    localparam int BC_W   = $clog2(BEAT_BYTES);
    localparam int SREG_W = (BEAT_BYTES - 1) * DATA_W;

    logic              pclk_q, vsync_q, href_q, active;
    logic [BC_W-1:0]   byte_cnt;
    logic [SREG_W-1:0] sreg;
    logic [BPL_W-1:0]  beat_in_line, bpl;
    logic [LINE_W-1:0] line_cnt, line_nxt;
    logic [IDX_W-1:0]  frame_idx;
    logic              pe;

    assign pe       = pclk & ~pclk_q;
    assign sof      = vsync & ~vsync_q;
    assign bpl      = burst ? {groups, 2'b00} : {2'b00, groups};
    assign line_nxt = line_cnt + 1'b1;

    // sync edges, byte packing, line and frame counting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pclk_q <= 1'b0; vsync_q <= 1'b0; href_q <= 1'b0; active <= 1'b0;
            byte_cnt <= '0; sreg <= '0; beat_in_line <= '0; line_cnt <= '0;
            frame_idx <= '0; beat_valid <= 1'b0; beat <= '0; lines_done <= 1'b0;
        end else begin
            pclk_q     <= pclk;
            vsync_q    <= vsync;
            beat_valid <= 1'b0;
            lines_done <= 1'b0;
            if (sof) begin
                active       <= arm;
                line_cnt     <= '0;
                beat_in_line <= '0;
                byte_cnt     <= '0;
                frame_idx    <= '0;
                href_q       <= 1'b0;
            end else if (pe) begin
                href_q <= href;
                if (active && href && beat_in_line < bpl) begin
                    if (byte_cnt == BC_W'(BEAT_BYTES - 1)) begin
                        beat_valid   <= 1'b1;
                        beat.data    <= {data, sreg};
                        beat.idx     <= frame_idx;
                        frame_idx    <= frame_idx + 1'b1;
                        beat_in_line <= beat_in_line + 1'b1;
                    end else begin
                        sreg[byte_cnt*DATA_W +: DATA_W] <= data;
                    end
                    byte_cnt <= byte_cnt + 1'b1;
                end
                if (active && href_q && !href) begin
                    beat_in_line <= '0;
                    byte_cnt     <= '0;
                    line_cnt     <= line_nxt;
                    if (line_nxt == lines) begin
                        active     <= 1'b0;
                        lines_done <= 1'b1;
                    end
                end
            end
        end
    end

    assert_sof_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sof |=> (line_cnt == '0 && frame_idx == '0 && beat_in_line == '0));
    assert_beat_on_edge_R1: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid |-> $past(pe && href && active));
endmodule

// File: rtl/cam_wr_issue.sv
// Beat buffer and write issuer. Holds up to DEPTH beats and replays each
// group (1 or 4 beats) to every enabled target in target order, holding the
// request stable until acknowledged. Assumes DEPTH is a power of two >= 4.
module cam_wr_issue
    import cam_cap_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               beat_valid,
    input  beat_t              beat,
    input  logic               burst,
    input  logic [NTGT-1:0]    tgt_mask,
    input  logic [NTGT*ADDR_W-1:0] bases,
    input  logic               wr_ack,
    output logic               wr_req,
    output logic [ADDR_W-1:0]  wr_addr,
    output logic [BEAT_W-1:0]  wr_data,
    output logic               wr_first,
    output logic               wr_last,
    output logic               idle,
    output logic               ovf
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;
    localparam int TGT_W = $clog2(NTGT);
    localparam int K_W   = 2;

    beat_t             fifo_q [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  count, grp_need, pop_n;
    logic              busy, push, start, drop, nxt_found, grp_done;
    logic [TGT_W-1:0]  tgt, first_tgt, nxt_tgt;
    logic [K_W-1:0]    k, grp_last;
    logic [NTGT-1:0]   mask_q;
    logic [ADDR_W-1:0] base_arr [NTGT];
    beat_t             cur;

    for (genvar g = 0; g < NTGT; g++) begin : g_base
        assign base_arr[g] = bases[g*ADDR_W +: ADDR_W];
    end

    assign push     = beat_valid && (count != CNT_W'(DEPTH));
    assign ovf      = beat_valid && (count == CNT_W'(DEPTH));
    assign grp_need = burst ? CNT_W'(4) : CNT_W'(1);
    assign start    = !busy && (count >= grp_need);
    assign drop     = start && (tgt_mask == '0);
    assign cur      = fifo_q[rd_ptr + PTR_W'(k)];
    assign wr_req   = busy;
    assign wr_addr  = base_arr[tgt] + ADDR_W'({cur.idx, 3'b000});
    assign wr_data  = cur.data;
    assign wr_first = (k == '0);
    assign wr_last  = (k == grp_last);
    assign idle     = !busy && (count == '0);
    assign grp_done = busy && wr_ack && (k == grp_last) && !nxt_found;
    assign pop_n    = grp_done ? CNT_W'(grp_last) + 1'b1 : (drop ? CNT_W'(1) : '0);

    // pick the lowest enabled target, and the next one above the current
    always_comb begin
        first_tgt = '0;
        nxt_tgt   = '0;
        nxt_found = 1'b0;
        for (int t = NTGT - 1; t >= 0; t--) begin
            if (tgt_mask[t]) first_tgt = TGT_W'(t);
            if (mask_q[t] && t > int'(tgt)) begin
                nxt_found = 1'b1;
                nxt_tgt   = TGT_W'(t);
            end
        end
    end

    // buffer storage write
    always_ff @(posedge clk) begin
        if (push) fifo_q[wr_ptr] <= beat;
    end

    // buffer pointers and occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0; rd_ptr <= '0; count <= '0;
        end else begin
            wr_ptr <= wr_ptr + PTR_W'(push);
            rd_ptr <= rd_ptr + PTR_W'(pop_n);
            count  <= count + CNT_W'(push) - pop_n;
        end
    end

    // group issue sequencing over beats and targets
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0; tgt <= '0; k <= '0; grp_last <= '0; mask_q <= '0;
        end else if (start && !drop) begin
            busy     <= 1'b1;
            tgt      <= first_tgt;
            k        <= '0;
            grp_last <= burst ? K_W'(3) : K_W'(0);
            mask_q   <= tgt_mask;
        end else if (busy && wr_ack) begin
            if (k != grp_last) begin
                k <= k + 1'b1;
            end else begin
                k <= '0;
                if (nxt_found) tgt  <= nxt_tgt;
                else           busy <= 1'b0;
            end
        end
    end

    assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req && !wr_ack |=> wr_req && $stable(wr_addr) && $stable(wr_data));
    assert_run_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req && wr_ack && !wr_last |=> wr_req && !wr_first);
    assert_no_overflow_R13: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));
endmodule

// File: rtl/cam_capture.sv
// Top of the camera capture engine: status flags with qualified clears,
// arming and auto mode, interrupt, and wiring of front end, write issuer and
// master clock divider. Assumes configuration is static while a frame runs.
module cam_capture
    import cam_cap_pkg::*;
#(
    parameter int GRP_W      = 8,
    parameter int LINE_W     = 10,
    parameter int DIV_W      = 8,
    parameter int FIFO_DEPTH = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cam_pclk,
    input  logic               cam_vsync,
    input  logic               cam_href,
    input  logic [7:0]         cam_data,
    output logic               cam_mclk,
    input  logic [DIV_W-1:0]   cfg_mclk_div,
    input  logic               cfg_mclk_en,
    input  logic [GRP_W-1:0]   cfg_line_groups,
    input  logic [LINE_W-1:0]  cfg_lines,
    input  logic               cfg_burst,
    input  logic               cfg_auto,
    input  logic               cfg_disp_en,
    input  logic               cfg_ai_en,
    input  logic [31:0]        cfg_disp_base,
    input  logic [31:0]        cfg_r_base,
    input  logic [31:0]        cfg_g_base,
    input  logic [31:0]        cfg_b_base,
    input  logic               cfg_ie_start,
    input  logic               cfg_ie_finish,
    input  logic               sts_wr,
    input  logic [7:0]         sts_wdata,
    output logic [3:0]         sts_flags,
    output logic               irq,
    output logic               wr_req,
    input  logic               wr_ack,
    output logic [31:0]        wr_addr,
    output logic [63:0]        wr_data,
    output logic               wr_first,
    output logic               wr_last
);
    logic  sof, beat_valid, lines_done, idle, ovf_hit, arm;
    logic  start_f, fin_f, arm_f, ovf_f, fin_pend;
    logic  clr_start, clr_fin, clr_ovf;
    beat_t beat;

    assign clr_start = sts_wr && sts_wdata[ST_SOF] && sts_wdata[ST_SOF_WE];
    assign clr_fin   = sts_wr && sts_wdata[ST_EOF] && sts_wdata[ST_EOF_WE];
    assign clr_ovf   = sts_wr && sts_wdata[ST_OVF] && sts_wdata[ST_OVF_WE];
    assign arm       = arm_f | cfg_auto;
    assign sts_flags = {ovf_f, arm_f, fin_f, start_f};
    assign irq       = (start_f & cfg_ie_start) | (fin_f & cfg_ie_finish);

    cam_mclk_div #(.DIV_W(DIV_W)) mclk_i (
        .clk(clk), .rst_n(rst_n), .en(cfg_mclk_en), .div(cfg_mclk_div),
        .mclk(cam_mclk)
    );

    cam_cap_front #(.DATA_W(8), .GRP_W(GRP_W), .LINE_W(LINE_W)) front_i (
        .clk(clk), .rst_n(rst_n), .pclk(cam_pclk), .vsync(cam_vsync),
        .href(cam_href), .data(cam_data), .arm(arm), .groups(cfg_line_groups),
        .burst(cfg_burst), .lines(cfg_lines), .sof(sof),
        .beat_valid(beat_valid), .beat(beat), .lines_done(lines_done)
    );

    cam_wr_issue #(.DEPTH(FIFO_DEPTH)) issue_i (
        .clk(clk), .rst_n(rst_n), .beat_valid(beat_valid), .beat(beat),
        .burst(cfg_burst),
        .tgt_mask({cfg_ai_en, cfg_ai_en, cfg_ai_en, cfg_disp_en}),
        .bases({cfg_b_base, cfg_g_base, cfg_r_base, cfg_disp_base}),
        .wr_ack(wr_ack), .wr_req(wr_req), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_first(wr_first), .wr_last(wr_last),
        .idle(idle), .ovf(ovf_hit)
    );

    // sticky flags, arm bit and pending-finish tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_f <= 1'b0; fin_f <= 1'b0; arm_f <= 1'b0;
            ovf_f <= 1'b0; fin_pend <= 1'b0;
        end else begin
            if (sof)            start_f <= 1'b1;
            else if (clr_start) start_f <= 1'b0;

            if (sts_wr && sts_wdata[ST_ARM_WE]) arm_f <= sts_wdata[ST_ARM];
            else if (sof && !cfg_auto)          arm_f <= 1'b0;

            if (sof)                   fin_pend <= 1'b0;
            else if (lines_done)       fin_pend <= 1'b1;
            else if (fin_pend && idle) fin_pend <= 1'b0;

            if (fin_pend && idle && !sof) fin_f <= 1'b1;
            else if (clr_fin)             fin_f <= 1'b0;

            if (ovf_hit)      ovf_f <= 1'b1;
            else if (clr_ovf) ovf_f <= 1'b0;
        end
    end

    assert_start_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start_f && !clr_start |=> start_f);
    assert_finish_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fin_f && !clr_fin |=> fin_f);
    assert_finish_drained_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fin_f) |-> !wr_req);
    assert_sof_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sof |=> start_f);
endmodule

// File: tb/cam_capture_tb_top.sv
// Directed bench for the camera capture engine.
module cam_capture_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cam_pclk = 0, cam_vsync = 0, cam_href = 0;
    logic [7:0] cam_data = 0;
    logic cam_mclk;
    logic [7:0] cfg_mclk_div = 0;
    logic cfg_mclk_en = 0;
    logic [7:0] cfg_line_groups = 1;
    logic [9:0] cfg_lines = 1;
    logic cfg_burst = 0, cfg_auto = 0, cfg_disp_en = 0, cfg_ai_en = 0;
    logic [31:0] base [4];
    logic cfg_ie_start = 0, cfg_ie_finish = 0;
    logic sts_wr = 0;
    logic [7:0] sts_wdata = 0;
    logic [3:0] sts_flags;
    logic irq, wr_req, wr_first, wr_last;
    logic wr_ack = 0;
    logic [31:0] wr_addr;
    logic [63:0] wr_data;

    int n_chk = 0, n_fail = 0, cycles = 0;
    int ack_delay = 0, ack_cnt = 0;
    bit ack_on = 1;
    int n_rec = 0, stall_err = 0, stalls = 0;
    logic [31:0] rec_addr [512];
    logic [63:0] rec_data [512];
    logic [1:0]  rec_fl   [512];
    bit pend_v = 0;
    logic [31:0] pend_addr;
    logic [63:0] pend_data;

    always #2 clk = ~clk;

    initial begin
        base[0] = 32'h1000_0000; base[1] = 32'h2000_0000;
        base[2] = 32'h3000_0000; base[3] = 32'h4000_0000;
    end

    cam_capture dut_i (
        .clk(clk), .rst_n(rst_n), .cam_pclk(cam_pclk), .cam_vsync(cam_vsync),
        .cam_href(cam_href), .cam_data(cam_data), .cam_mclk(cam_mclk),
        .cfg_mclk_div(cfg_mclk_div), .cfg_mclk_en(cfg_mclk_en),
        .cfg_line_groups(cfg_line_groups), .cfg_lines(cfg_lines),
        .cfg_burst(cfg_burst), .cfg_auto(cfg_auto), .cfg_disp_en(cfg_disp_en),
        .cfg_ai_en(cfg_ai_en), .cfg_disp_base(base[0]), .cfg_r_base(base[1]),
        .cfg_g_base(base[2]), .cfg_b_base(base[3]), .cfg_ie_start(cfg_ie_start),
        .cfg_ie_finish(cfg_ie_finish), .sts_wr(sts_wr), .sts_wdata(sts_wdata),
        .sts_flags(sts_flags), .irq(irq), .wr_req(wr_req), .wr_ack(wr_ack),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_first(wr_first),
        .wr_last(wr_last)
    );

    // memory responder: ack policy, recording of accepted beats, hold check
    always @(negedge clk) begin
        if (!rst_n) begin
            wr_ack = 0; ack_cnt = 0; pend_v = 0;
        end else begin
            if (pend_v && !(wr_req && wr_addr == pend_addr && wr_data == pend_data))
                stall_err++;
            if (wr_ack && ack_delay != 0) begin
                wr_ack = 0; ack_cnt = 0;
            end else if (wr_req && ack_on) begin
                if (ack_cnt >= ack_delay) wr_ack = 1;
                else begin ack_cnt++; wr_ack = 0; end
            end else begin
                wr_ack = 0; ack_cnt = 0;
            end
            if (wr_req && wr_ack && n_rec < 512) begin
                rec_addr[n_rec] = wr_addr; rec_data[n_rec] = wr_data;
                rec_fl[n_rec] = {wr_first, wr_last}; n_rec++;
            end
            pend_v = wr_req && !wr_ack;
            if (pend_v) stalls++;
            pend_addr = wr_addr; pend_data = wr_data;
        end
    end

    task automatic summary_and_end();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // watchdog
    always @(negedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            summary_and_end();
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pix(int seed, int l, int b);
        return 8'((seed + l * 37 + b * 5) & 255);
    endfunction

    function automatic logic [63:0] exp_beat(int seed, int bpl, int k);
        logic [63:0] r;
        int l = k / bpl;
        int j = k % bpl;
        for (int i = 0; i < 8; i++) r[i*8 +: 8] = pix(seed, l, 8 * j + i);
        return r;
    endfunction

    task automatic pclk_cycle(input logic h, input logic [7:0] d);
        @(negedge clk);
        cam_href = h; cam_data = d; cam_pclk = 0;
        repeat (2) @(negedge clk);
        cam_pclk = 1;
        repeat (2) @(negedge clk);
    endtask

    task automatic send_frame(input int lines, input int nbytes, input int seed);
        cam_vsync = 1;
        repeat (2) pclk_cycle(0, 0);
        cam_vsync = 0;
        repeat (2) pclk_cycle(0, 0);
        for (int l = 0; l < lines; l++) begin
            for (int b = 0; b < nbytes; b++) pclk_cycle(1, pix(seed, l, b));
            repeat (2) pclk_cycle(0, 0);
        end
        repeat (2) pclk_cycle(0, 0);
    endtask

    task automatic sts_write(input logic [7:0] v);
        @(negedge clk);
        sts_wr = 1; sts_wdata = v;
        @(negedge clk);
        sts_wr = 0; sts_wdata = 0;
        @(negedge clk);
    endtask

    task automatic wait_finish();
        for (int i = 0; i < 4000 && !sts_flags[1]; i++) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic cmp_writes(input string tag, input int nbeats, input int bpl,
                              input int seed, input int grp, input logic [3:0] mask);
        int p = 0;
        for (int g = 0; g < nbeats / grp; g++)
            for (int t = 0; t < 4; t++)
                if (mask[t])
                    for (int q = 0; q < grp; q++) begin
                        int idx = g * grp + q;
                        if (p < n_rec) begin
                            chk({tag, " R2/R12 addr"}, 64'(rec_addr[p]), 64'(base[t] + 32'(idx * 8)));
                            chk({tag, " R1 data"}, rec_data[p], exp_beat(seed, bpl, idx));
                            chk({tag, " R3 first/last"}, 64'(rec_fl[p]), 64'({q == 0, q == grp - 1}));
                        end
                        p++;
                    end
        chk({tag, " write count"}, 64'(n_rec), 64'(p));
    endtask

    task automatic t_reset();
        chk("R7 flags after reset", 64'(sts_flags), 64'h0);
        chk("R10 irq after reset", 64'(irq), 64'h0);
        chk("R3 no request after reset", 64'(wr_req), 64'h0);
        chk("R11 mclk after reset", 64'(cam_mclk), 64'h0);
    endtask

    task automatic measure_mclk(input logic [7:0] dv, input int exp);
        int t0 = 0, t1 = 0;
        logic prev;
        cfg_mclk_div = dv; cfg_mclk_en = 1;
        repeat (3) @(negedge clk);
        prev = cam_mclk;
        for (int i = 0; i < 2000 && t1 == 0; i++) begin
            @(negedge clk);
            if (cam_mclk && !prev) begin
                if (t0 == 0) t0 = cycles; else t1 = cycles;
            end
            prev = cam_mclk;
        end
        chk($sformatf("R11 mclk period div=%0d", dv), 64'(t1 - t0), 64'(exp));
    endtask

    task automatic t_mclk();
        int highs = 0;
        measure_mclk(8'd2, 6);
        measure_mclk(8'd0, 2);
        measure_mclk(8'd9, 20);
        cfg_mclk_en = 0;
        repeat (20) begin @(negedge clk); if (cam_mclk) highs++; end
        chk("R11 mclk low when disabled", 64'(highs), 64'h0);
    endtask

    task automatic t_single();
        n_rec = 0;
        cfg_burst = 0; cfg_line_groups = 3; cfg_lines = 2;
        cfg_disp_en = 1; cfg_ai_en = 0;
        sts_write(8'h30);
        chk("R8 arm bit set", 64'(sts_flags[2]), 64'h1);
        send_frame(2, 24, 11);
        wait_finish();
        chk("R5 start flag", 64'(sts_flags[0]), 64'h1);
        chk("R6 finish flag", 64'(sts_flags[1]), 64'h1);
        chk("R8 arm consumed", 64'(sts_flags[2]), 64'h0);
        cmp_writes("single", 6, 3, 11, 1, 4'b0001);
        sts_write(8'h0F);
    endtask

    task automatic t_trunc();
        n_rec = 0;
        cfg_line_groups = 2; cfg_lines = 2;
        sts_write(8'h30);
        send_frame(2, 20, 50);
        wait_finish();
        cmp_writes("R1 extra bytes ignored", 4, 2, 50, 1, 4'b0001);
        sts_write(8'h0F);
    endtask

    task automatic t_burst_stall();
        n_rec = 0; stalls = 0; stall_err = 0; ack_delay = 2;
        cfg_burst = 1; cfg_line_groups = 1; cfg_lines = 2;
        cfg_disp_en = 1; cfg_ai_en = 1;
        sts_write(8'h30);
        send_frame(2, 32, 77);
        wait_finish();
        chk("R6 finish after burst frame", 64'(sts_flags[1]), 64'h1);
        cmp_writes("burst", 8, 4, 77, 4, 4'b1111);
        chk("R4 stalls occurred", 64'(stalls > 0), 64'h1);
        chk("R4 request held during stall", 64'(stall_err), 64'h0);
        ack_delay = 0; cfg_burst = 0;
        sts_write(8'h0F);
    endtask

    task automatic t_unarmed();
        n_rec = 0;
        cfg_line_groups = 1; cfg_lines = 1; cfg_disp_en = 1; cfg_ai_en = 0;
        send_frame(1, 8, 3);
        repeat (200) @(negedge clk);
        chk("R8 unarmed frame start flag", 64'(sts_flags[0]), 64'h1);
        chk("R8 unarmed frame no writes", 64'(n_rec), 64'h0);
        chk("R8 unarmed frame no finish", 64'(sts_flags[1]), 64'h0);
        sts_write(8'h0F);
    endtask

    task automatic t_auto();
        cfg_auto = 1; cfg_disp_en = 0; cfg_ai_en = 1;
        cfg_line_groups = 2; cfg_lines = 1;
        for (int f = 0; f < 2; f++) begin
            n_rec = 0;
            send_frame(1, 16, 90 + f);
            wait_finish();
            chk($sformatf("R9 auto frame %0d finish", f), 64'(sts_flags[1]), 64'h1);
            cmp_writes($sformatf("R9 auto frame %0d", f), 2, 2, 90 + f, 1, 4'b1110);
            sts_write(8'h0F);
        end
        n_rec = 0;
        cfg_ai_en = 0;
        send_frame(1, 16, 5);
        repeat (200) @(negedge clk);
        chk("R12 no target enabled gives no writes", 64'(n_rec), 64'h0);
        cfg_auto = 0;
        sts_write(8'h0F);
    endtask

    task automatic t_status();
        cfg_disp_en = 1; cfg_line_groups = 1; cfg_lines = 1;
        sts_write(8'h30);
        send_frame(1, 8, 9);
        wait_finish();
        cfg_ie_start = 0; cfg_ie_finish = 0;
        @(negedge clk);
        chk("R10 irq masked", 64'(irq), 64'h0);
        cfg_ie_start = 1;
        @(negedge clk);
        chk("R10 irq on start flag", 64'(irq), 64'h1);
        sts_write(8'h05);
        chk("R7 flags kept without write-enable", 64'(sts_flags[1:0]), 64'h3);
        sts_write(8'h03);
        chk("R7 start cleared, finish kept", 64'(sts_flags[1:0]), 64'h2);
        chk("R10 irq drops with start flag", 64'(irq), 64'h0);
        cfg_ie_finish = 1;
        @(negedge clk);
        chk("R10 irq on finish flag", 64'(irq), 64'h1);
        sts_write(8'h0C);
        chk("R7 finish cleared", 64'(sts_flags[1:0]), 64'h0);
        cfg_ie_start = 0; cfg_ie_finish = 0;
    endtask

    task automatic t_ovf();
        n_rec = 0; ack_on = 0;
        cfg_burst = 0; cfg_disp_en = 1; cfg_ai_en = 0;
        cfg_line_groups = 10; cfg_lines = 1;
        sts_write(8'h30);
        send_frame(1, 80, 21);
        chk("R13 overflow flag set", 64'(sts_flags[3]), 64'h1);
        chk("R6 no finish while writes pending", 64'(sts_flags[1]), 64'h0);
        ack_on = 1;
        wait_finish();
        chk("R6 finish after drain", 64'(sts_flags[1]), 64'h1);
        cmp_writes("R13 kept beats", 8, 10, 21, 1, 4'b0001);
        sts_write(8'h40);
        chk("R7 overflow kept without enable", 64'(sts_flags[3]), 64'h1);
        sts_write(8'hC0);
        chk("R7 overflow cleared", 64'(sts_flags[3]), 64'h0);
        sts_write(8'h0F);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1;
        repeat (2) @(negedge clk);
        t_reset();
        t_mclk();
        t_single();
        t_trunc();
        t_burst_stall();
        t_unarmed();
        t_auto();
        t_status();
        t_ovf();
        summary_and_end();
    end
endmodule